// File: doc/BRIEF.md
# Multicast Scatter Tree

This block carries data words from a single global-buffer port down to an array of processing-element leaves through a binary tree of small switches. Every word comes with a destination bitmask of one bit per leaf. Each switch keeps only two enable bits, one for its upper child and one for its lower child. An enable bit is set when any leaf in that child's subtree is a destination. A word therefore moves only along the links that lead to its destinations. The same path covers unicast, multicast and broadcast.

Every tree level holds one pipeline register. Each leaf also has its own output register. Flow control between neighbouring stages uses a single on/off stop signal. A stage keeps its word until every child it must feed has its stop signal low. A multicast copy is therefore never dropped or sent twice.

A mode input selects where the mask comes from. In cycle mode, each data word carries its own mask. In epoch mode, a configuration-load strobe latches a mask once, and that mask is then used for every following word.

Top module: `scatter_tree`

## Requirements
- R1: After a synchronous active-low reset, every `leaf_valid` bit is low and `in_stop` is low while `cfg_load` is low.
- R2: A word whose mask has one bit p set is delivered once, with its data unchanged, on leaf port p, which is `leaf_valid[p]` and `leaf_data[p*DW +: DW]`. No other leaf receives it.
- R3: A word whose mask has several bits set, up to all bits, is delivered exactly once to every leaf whose bit is set and to no other leaf.
- R4: When no stop is asserted, a word accepted at clock edge k appears on its leaf outputs right after edge k+LEVELS. LEVELS is the number of switch levels, and the leaf register is one more stage.
- R5: When no stop is asserted, the tree accepts one word per cycle with `in_stop` held low, and each leaf receives its words in the order they were sent.
- R6: A leaf holding `leaf_stop` high stalls the words addressed to it. The stall propagates up to `in_stop`. No word is lost or duplicated at any destination, and after the stop is released all words arrive in order.
- R7: A word whose effective mask is all zero is accepted without stalling and produces no output on any leaf.
- R8: When `cfg_mode` is 1 (epoch mode), a cycle with `cfg_load` high latches `in_mask`. Data words then use the latched mask, and their own `in_mask` has no effect.
- R9: In any cycle where `cfg_load` is high, `in_stop` is high and no data word is taken.
- R10: When `cfg_mode` is 0 (cycle mode), each word is routed by its own `in_mask`, even after an epoch mask was latched.
- R11: While a leaf holds `leaf_stop` high, its `leaf_valid` stays high and `leaf_data` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 1 | 0: per-word mask, 1: latched epoch mask |
| cfg_load | input | 1 | Latch `in_mask` as the epoch mask |
| in_valid | input | 1 | Data word present on the buffer side |
| in_data | input | DW | Data word |
| in_mask | input | LEAVES | Destination mask, bit p means leaf p |
| in_stop | output | 1 | On/off stop toward the buffer side |
| leaf_valid | output | LEAVES | Word present at each leaf |
| leaf_data | output | LEAVES*DW | Leaf p data in bits p*DW +: DW |
| leaf_stop | input | LEAVES | On/off stop from each leaf |

## Verification
The assertions assume the buffer side follows the on/off rule: a word counts as taken only in a cycle where `in_stop` is low. The bench presents a word and keeps it present until it sees `in_stop` low at a falling edge. The assertions also assume that leaves change `leaf_stop` only between clock edges. The bench drives every input shortly after a rising edge and samples every output at the falling edge.

// File: rtl/scatter_pkg.sv
// Shared defaults for the scatter tree.
// Assumes: leaf count is a power of two derived from the level count.
package scatter_pkg;
    localparam int DEF_LEVELS = 4;
    localparam int DEF_DW     = 16;

    // Lowest mask bit owned by node i of a level whose slices are sw bits wide
    function automatic int slice_base(input int leaves, input int i, input int sw);
        return leaves - (i + 1) * sw;
    endfunction
endpackage

// File: rtl/scatter_switch.sv
// One tree switch: a single pipeline register holding a word, its subtree mask
// slice and two enable bits (upper child = upper half of the slice).
// Assumes: load is only raised when stop_out is low (parent obeys on/off stop).
module scatter_switch #(
    parameter int DW = 16,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] ld_data,
    input  logic [SW-1:0] ld_mask,
    input  logic          stop_up,
    input  logic          stop_dn,
    output logic [DW-1:0] data,
    output logic [SW-1:0] mask,
    output logic          send_up,
    output logic          send_dn,
    output logic          stop_out
);
    localparam int HW = SW / 2;

    logic valid_q, en_up_q, en_dn_q, go;
    logic [DW-1:0] data_q;
    logic [SW-1:0] mask_q;

    // Control state: occupancy and the two per-child enable bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            en_up_q <= 1'b0;
            en_dn_q <= 1'b0;
        end else if (load) begin
            valid_q <= 1'b1;
            en_up_q <= |ld_mask[SW-1:HW];
            en_dn_q <= |ld_mask[HW-1:0];
        end else if (go) begin
            valid_q <= 1'b0;
        end
    end

    // Payload capture on load
    always_ff @(posedge clk) begin
        if (load) begin
            data_q <= ld_data;
            mask_q <= ld_mask;
        end
    end

    // Advance only when every enabled child can take the word
    always_comb begin
        go       = !(en_up_q && stop_up) && !(en_dn_q && stop_dn);
        send_up  = valid_q && go && en_up_q;
        send_dn  = valid_q && go && en_dn_q;
        stop_out = valid_q && !go;
        data     = data_q;
        mask     = mask_q;
    end

    // R6
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !stop_out);

    // R6
    hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_out |=> (valid_q && $stable(data_q) && $stable(mask_q)));
endmodule

// File: rtl/scatter_leaf.sv
// Leaf output register: holds one word per leaf under on/off stop.
// Assumes: sel is the parent's stored mask bit for this leaf.
module scatter_leaf #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] ld_data,
    input  logic          sel,
    input  logic          stop_in,
    output logic          valid,
    output logic [DW-1:0] data,
    output logic          stop_out
);
    logic valid_q;
    logic [DW-1:0] data_q;

    // Occupancy: set on load, cleared when the leaf takes the word
    always_ff @(posedge clk) begin
        if (!rst_n)       valid_q <= 1'b0;
        else if (load)    valid_q <= 1'b1;
        else if (!stop_in) valid_q <= 1'b0;
    end

    // Payload capture on load
    always_ff @(posedge clk) begin
        if (load) data_q <= ld_data;
    end

    // Outputs and stop toward the bottom switch
    always_comb begin
        valid    = valid_q;
        data     = data_q;
        stop_out = valid_q && stop_in;
    end

    // R2
    leaf_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> sel);

    // R11
    leaf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && stop_in) |=> (valid_q && $stable(data_q)));
endmodule

// File: rtl/scatter_tree.sv
// Multicast scatter tree top: mask source select, entry stall, switch levels
// and leaf registers. Node n (heap order) has children 2n (upper) and 2n+1.
// Assumes: a word is taken only in a cycle where in_stop is low.
module scatter_tree
    import scatter_pkg::*;
#(
    parameter int LEVELS = DEF_LEVELS,
    parameter int DW     = DEF_DW,
    parameter int LEAVES = 1 << LEVELS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_mode,
    input  logic                 cfg_load,
    input  logic                 in_valid,
    input  logic [DW-1:0]        in_data,
    input  logic [LEAVES-1:0]    in_mask,
    output logic                 in_stop,
    output logic [LEAVES-1:0]    leaf_valid,
    output logic [LEAVES*DW-1:0] leaf_data,
    input  logic [LEAVES-1:0]    leaf_stop
);
    localparam int NODES = 2 * LEAVES - 1;

    logic [LEAVES-1:0] epoch_mask, eff_mask;
    logic              accept, root_load;
    logic [NODES:1]    n_stop;
    logic [LEAVES-1:1] snd_up, snd_dn;
    logic [DW-1:0]     n_data [1:NODES];
    logic [LEVELS-1:0][LEAVES-1:0] lv_mask;

    // Epoch mask register, written by the config strobe
    always_ff @(posedge clk) begin
        if (!rst_n)        epoch_mask <= '0;
        else if (cfg_load) epoch_mask <= in_mask;
    end

    // Entry control: mask select, stall during config load, zero-mask drop
    always_comb begin
        eff_mask  = cfg_mode ? epoch_mask : in_mask;
        in_stop   = cfg_load || n_stop[1];
        accept    = in_valid && !in_stop;
        root_load = accept && (|eff_mask);
    end

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int SW = LEAVES >> l;
        for (genvar i = 0; i < (1 << l); i++) begin : g_sw
            localparam int N    = (1 << l) + i;
            localparam int BASE = slice_base(LEAVES, i, SW);
            logic          ld;
            logic [SW-1:0] ld_m;
            logic [DW-1:0] ld_d;
            if (l == 0) begin : g_root
                assign ld   = root_load;
                assign ld_m = eff_mask;
                assign ld_d = in_data;
            end else begin : g_inner
                assign ld   = (N % 2 == 0) ? snd_up[N/2] : snd_dn[N/2];
                assign ld_m = lv_mask[l-1][BASE +: SW];
                assign ld_d = n_data[N/2];
            end
            scatter_switch #(.DW(DW), .SW(SW)) u_sw (
                .clk(clk), .rst_n(rst_n), .load(ld), .ld_data(ld_d), .ld_mask(ld_m),
                .stop_up(n_stop[2*N]), .stop_dn(n_stop[2*N+1]),
                .data(n_data[N]), .mask(lv_mask[l][BASE +: SW]),
                .send_up(snd_up[N]), .send_dn(snd_dn[N]), .stop_out(n_stop[N])
            );
        end
    end

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        localparam int N    = LEAVES + i;
        localparam int PORT = LEAVES - 1 - i;
        logic ld;
        assign ld = (N % 2 == 0) ? snd_up[N/2] : snd_dn[N/2];
        scatter_leaf #(.DW(DW)) u_leaf (
            .clk(clk), .rst_n(rst_n), .load(ld), .ld_data(n_data[N/2]),
            .sel(lv_mask[LEVELS-1][PORT]), .stop_in(leaf_stop[PORT]),
            .valid(leaf_valid[PORT]), .data(n_data[N]), .stop_out(n_stop[N])
        );
        assign leaf_data[PORT*DW +: DW] = n_data[N];
    end

    // R7
    zero_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_stop && (eff_mask == '0)) |=> !n_stop[1]);
endmodule

// File: tb/sim_scatter_tree.sv
module sim_scatter_tree;
    localparam int LEVELS = 4;
    localparam int DW     = 16;
    localparam int LEAVES = 1 << LEVELS;

    logic clk = 0, rst_n = 0, cfg_mode = 0, cfg_load = 0, in_valid = 0;
    logic [DW-1:0] in_data = '0;
    logic [LEAVES-1:0] in_mask = '0, leaf_stop = '0;
    logic in_stop;
    logic [LEAVES-1:0] leaf_valid;
    logic [LEAVES*DW-1:0] leaf_data;

    int tests = 0, fails = 0, cyc = 0;
    int rx_cnt [LEAVES];
    int rx_cyc [LEAVES];
    logic [DW-1:0] rx_log [LEAVES][16];
    bit stop_seen = 0;

    scatter_tree #(.LEVELS(LEVELS), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_load(cfg_load),
        .in_valid(in_valid), .in_data(in_data), .in_mask(in_mask), .in_stop(in_stop),
        .leaf_valid(leaf_valid), .leaf_data(leaf_data), .leaf_stop(leaf_stop)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: record every leaf transfer at the falling edge
    always @(negedge clk) begin
        for (int k = 0; k < LEAVES; k++) begin
            if (leaf_valid[k] && !leaf_stop[k]) begin
                if (rx_cnt[k] == 0) rx_cyc[k] = cyc;
                if (rx_cnt[k] < 16) rx_log[k][rx_cnt[k]] = leaf_data[k*DW +: DW];
                rx_cnt[k]++;
            end
        end
        if (in_valid && in_stop) stop_seen = 1;
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc == 20000) begin
            fails++; tests++;
            $display("FAIL watchdog: run hung, actual cyc=%0d expected < 20000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear();
        for (int k = 0; k < LEAVES; k++) begin rx_cnt[k] = 0; rx_cyc[k] = 0; end
        stop_seen = 0;
    endtask

    function automatic int total();
        int s = 0;
        for (int k = 0; k < LEAVES; k++) s += rx_cnt[k];
        return s;
    endfunction

    task automatic send(input logic [LEAVES-1:0] m, input logic [DW-1:0] d, output int acc);
        bit ok;
        in_valid = 1; in_mask = m; in_data = d;
        do begin
            @(negedge clk); ok = !in_stop;
            @(posedge clk); #1;
        end while (!ok);
        acc = cyc;
        in_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(leaf_valid == '0, "R1 leaf_valid", leaf_valid, 0);
        chk(in_stop == 0, "R1 in_stop", in_stop, 0);
    endtask

    task automatic t_unicast();
        int a;
        clear();
        send(16'h0020, 16'hA5A5, a);
        idle(10);
        chk(rx_cnt[5] == 1, "R2 count leaf5", rx_cnt[5], 1);
        chk(rx_log[5][0] == 16'hA5A5, "R2 data leaf5", rx_log[5][0], 16'hA5A5);
        chk(total() == 1, "R2 total", total(), 1);
    endtask

    task automatic t_latency();
        int a;
        clear();
        send(16'h0001, 16'h3333, a);
        idle(10);
        chk(rx_cyc[0] - a == LEVELS, "R4 latency", rx_cyc[0] - a, LEVELS);
    endtask

    task automatic t_multicast();
        int a;
        clear();
        send(16'h8421, 16'h4242, a);
        idle(10);
        chk(total() == 4, "R3 multicast total", total(), 4);
        chk(rx_cnt[0] == 1 && rx_cnt[5] == 1 && rx_cnt[10] == 1 && rx_cnt[15] == 1,
            "R3 multicast leaves", {rx_cnt[15][3:0], rx_cnt[10][3:0], rx_cnt[5][3:0], rx_cnt[0][3:0]}, 16'h1111);
        chk(rx_log[10][0] == 16'h4242, "R3 multicast data", rx_log[10][0], 16'h4242);
        clear();
        send(16'hFFFF, 16'hB0B0, a);
        idle(10);
        chk(total() == LEAVES, "R3 broadcast total", total(), LEAVES);
    endtask

    task automatic t_stream();
        int a, start;
        bit ordered = 1;
        clear();
        start = cyc;
        for (int k = 0; k < 8; k++) send(16'h1008, DW'(16'h5000 + k), a);
        chk(cyc - start == 8, "R5 one word per cycle", cyc - start, 8);
        chk(stop_seen == 0, "R5 no stall", stop_seen, 0);
        idle(10);
        for (int k = 0; k < 8; k++)
            if (rx_log[3][k] != DW'(16'h5000 + k) || rx_log[12][k] != DW'(16'h5000 + k)) ordered = 0;
        chk(rx_cnt[3] == 8 && rx_cnt[12] == 8, "R5 counts", rx_cnt[3] + rx_cnt[12], 16);
        chk(ordered, "R5 order", ordered, 1);
    endtask

    task automatic t_backpressure();
        bit ordered = 1;
        clear();
        leaf_stop = 16'h0004;
        fork
            begin
                int a;
                for (int k = 0; k < 8; k++) send(16'h0084, DW'(16'h6000 + k), a);
            end
            begin
                idle(30);
                chk(stop_seen == 1, "R6 stall reaches in_stop", stop_seen, 1);
                chk(rx_cnt[2] == 0, "R6 stopped leaf idle", rx_cnt[2], 0);
                chk(leaf_valid[2] && leaf_data[2*DW +: DW] == 16'h6000, "R11 held word",
                    leaf_data[2*DW +: DW], 16'h6000);
                idle(5);
                chk(leaf_valid[2] && leaf_data[2*DW +: DW] == 16'h6000, "R11 still held",
                    leaf_data[2*DW +: DW], 16'h6000);
                leaf_stop = '0;
            end
        join
        idle(15);
        for (int k = 0; k < 8; k++)
            if (rx_log[2][k] != DW'(16'h6000 + k) || rx_log[7][k] != DW'(16'h6000 + k)) ordered = 0;
        chk(rx_cnt[2] == 8 && rx_cnt[7] == 8, "R6 no loss or duplicate", rx_cnt[2] * 100 + rx_cnt[7], 808);
        chk(ordered, "R6 order", ordered, 1);
        chk(total() == 16, "R6 total", total(), 16);
    endtask

    task automatic t_zero();
        int a, start;
        clear();
        start = cyc;
        send(16'h0000, 16'hDEAD, a);
        chk(cyc - start == 1, "R7 no stall", cyc - start, 1);
        idle(10);
        chk(total() == 0, "R7 no output", total(), 0);
    endtask

    task automatic t_epoch();
        int a;
        clear();
        cfg_mode = 1; cfg_load = 1; in_mask = 16'h0030; in_valid = 1; in_data = 16'h8888;
        @(negedge clk);
        chk(in_stop == 1, "R9 stall on load", in_stop, 1);
        @(posedge clk); #1;
        cfg_load = 0; in_mask = 16'h0001;
        @(negedge clk);
        chk(in_stop == 0, "R9 released after load", in_stop, 0);
        @(posedge clk); #1;
        in_valid = 0;
        idle(10);
        chk(rx_cnt[4] == 1 && rx_cnt[5] == 1, "R8 latched mask used", rx_cnt[4] + rx_cnt[5], 2);
        chk(rx_cnt[0] == 0, "R8 word mask ignored", rx_cnt[0], 0);
        chk(total() == 2, "R9 single acceptance", total(), 2);
        send(16'hFFFF, 16'h9999, a);
        idle(10);
        chk(total() == 4 && rx_log[4][1] == 16'h9999, "R8 epoch held", total(), 4);
    endtask

    task automatic t_cycle_again();
        int a;
        clear();
        cfg_mode = 0;
        send(16'h0100, 16'h7777, a);
        idle(10);
        chk(rx_cnt[8] == 1 && total() == 1, "R10 per-word mask", total(), 1);
    endtask

    initial begin
        for (int k = 0; k < LEAVES; k++) begin rx_cnt[k] = 0; rx_cyc[k] = 0; end
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        @(posedge clk); #1;
        t_unicast();
        t_latency();
        t_multicast();
        t_stream();
        t_backpressure();
        t_zero();
        t_epoch();
        t_cycle_again();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule